// File: doc/BRIEF.md
# Multicart Mapper Register File

This block is the write side of a bank-switching controller for a multigame cartridge. It watches CPU writes and keeps six 8-bit registers: an AND mask and an XOR mask for program memory, an AND mask and an XOR mask for character memory, a control byte and a user byte. All six values are driven out continuously. Downstream address-mapping logic combines them into bank numbers.

The four masks sit in the window from $5000 to $5FFF. Only the two lowest address bits pick one of them, so the rest of the window mirrors the four canonical ports. If address bit 2 of the same write is set, the control byte is also loaded with the same data. The user byte is written from the top of the CPU space. Control bit 5 decides whether that range starts at $6000 or at $8000. The written data is stored as given, and no ROM data is combined into it.

Top module: `mcart_regfile`

## Requirements
- R1: After reset, all six register outputs read $00.
- R2: A strobed write to $5000, $5001, $5002 or $5003 loads program AND, program XOR, character AND or character XOR respectively: address bit 1 = 0 selects program and 1 selects character, address bit 0 = 0 selects AND and 1 selects XOR.
- R3: Every address in $5000-$5FFF reaches the same mask as the canonical port with equal address bits 1:0.
- R4: A write in $5000-$5FFF with address bit 2 set loads the control byte and the selected mask with the same data, on the same clock edge.
- R5: A write in $5000-$5FFF with address bit 2 clear leaves the control byte unchanged.
- R6: While control bit 5 is 0, writes to $8000-$FFFF load the user byte, and writes to $6000-$7FFF leave it unchanged.
- R7: While control bit 5 is 1, writes anywhere in $6000-$FFFF load the user byte.
- R8: The user byte takes exactly the written data, including $00 and $FF, with no other value combined in.
- R9: Strobed writes below $5000 change no register.
- R10: Without the write strobe, no register changes, whatever the address and data.
- R11: Writes in $5000-$5FFF never change the user byte. Writes to $6000-$FFFF never change the masks or the control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address of the current access |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, active high for one cycle per write |
| prg_and | output | 8 | Program bank AND mask |
| prg_xor | output | 8 | Program bank XOR mask |
| chr_and | output | 8 | Character bank AND mask |
| chr_xor | output | 8 | Character bank XOR mask |
| ctrl | output | 8 | Control byte; bit 5 moves the user window |
| user | output | 8 | User bank byte |

## Verification
Each write is presented for one cycle and is captured by the next rising edge. All six outputs must therefore show the result one edge after the strobe, and they must not change before that edge. The driver applies a write on a falling edge and queues the full expected register set. The monitor pops that entry one time unit after the following rising edge and compares all six outputs at once. A change that is late, early or on the wrong register therefore shows as a mismatch at that exact cycle. Idle cycles and writes that must be ignored also queue an entry, so a register that holds its value is checked as well.

// File: rtl/mcart_regfile.sv
module mcart_regfile #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int UWIN_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          cpu_wr,
  output logic [DW-1:0] prg_and,
  output logic [DW-1:0] prg_xor,
  output logic [DW-1:0] chr_and,
  output logic [DW-1:0] chr_xor,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] user
);

  localparam int TOP = AW - 4;

  logic       in_win, hi_32k, hi_24k, usr_hit, win_wr;
  logic [1:0] sel;

  assign in_win  = cpu_addr[AW-1:TOP] == 4'h5;
  assign hi_32k  = cpu_addr[AW-1];
  assign hi_24k  = hi_32k | (cpu_addr[AW-1:AW-3] == 3'b011);
  assign usr_hit = ctrl[UWIN_BIT] ? hi_24k : hi_32k;
  assign win_wr  = cpu_wr & in_win;
  assign sel     = cpu_addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_and <= '0;
      prg_xor <= '0;
      chr_and <= '0;
      chr_xor <= '0;
      ctrl    <= '0;
      user    <= '0;
    end else begin
      if (win_wr) begin
        case (sel)
          2'd0: prg_and <= cpu_data;
          2'd1: prg_xor <= cpu_data;
          2'd2: chr_and <= cpu_data;
          default: chr_xor <= cpu_data;
        endcase
        if (cpu_addr[2]) ctrl <= cpu_data;
      end
      if (cpu_wr && usr_hit) user <= cpu_data;
    end
  end

  // R2
  prg_and_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_win && sel == 2'd0) |=> prg_and == $past(cpu_data));
  // R2
  chr_xor_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_win && sel == 2'd3) |=> chr_xor == $past(cpu_data));
  // R4
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_win && cpu_addr[2]) |=> ctrl == $past(cpu_data));
  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && in_win && cpu_addr[2]) |=> $stable(ctrl));
  // R8
  user_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && usr_hit) |=> user == $past(cpu_data));
  // R6
  user_low_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !ctrl[UWIN_BIT] && !hi_32k) |=> $stable(user));
  // R9
  below_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[AW-1:TOP] < 4'h5) |=> ($stable(prg_and) && $stable(prg_xor)
      && $stable(chr_and) && $stable(chr_xor) && $stable(ctrl) && $stable(user)));
  // R10
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(prg_and) && $stable(prg_xor) && $stable(chr_and)
      && $stable(chr_xor) && $stable(ctrl) && $stable(user)));

endmodule

// File: tb/mcart_regfile_tb.sv
module mcart_regfile_tb;
  logic clk = 0, rst_n = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [7:0]  prg_and, prg_xor, chr_and, chr_xor, ctrl, user;

  mcart_regfile u_dut (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .prg_and(prg_and), .prg_xor(prg_xor), .chr_and(chr_and),
    .chr_xor(chr_xor), .ctrl(ctrl), .user(user));

  always #2 clk = ~clk;

  typedef struct { logic [47:0] regs; string tag; } item_t;
  item_t q[$];
  logic [7:0] m_pa = 0, m_px = 0, m_ca = 0, m_cx = 0, m_ct = 0, m_us = 0;
  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic step(input bit wr, input logic [15:0] a, input logic [7:0] d, input string tag);
    item_t it;
    @(negedge clk);
    cpu_wr = wr; cpu_addr = a; cpu_data = d;
    if (wr) begin
      if (a >= 16'h5000 && a <= 16'h5FFF) begin
        if (a[1:0] == 2'd0) m_pa = d;
        if (a[1:0] == 2'd1) m_px = d;
        if (a[1:0] == 2'd2) m_ca = d;
        if (a[1:0] == 2'd3) m_cx = d;
        if (a[2]) m_ct = d;
      end
      if ((m_ct[5] && a >= 16'h6000) || (!m_ct[5] && a >= 16'h8000)) m_us = d;
    end
    it.regs = {m_pa, m_px, m_ca, m_cx, m_ct, m_us};
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [47:0] act;
      it = q.pop_front();
      act = {prg_and, prg_xor, chr_and, chr_xor, ctrl, user};
      compared++;
      if (act !== it.regs) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.regs);
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #10;
    compared++;
    if ({prg_and, prg_xor, chr_and, chr_xor, ctrl, user} !== 48'h0) begin
      mismatched++;
      $display("FAIL R1: actual %h expected 0", {prg_and, prg_xor, chr_and, chr_xor, ctrl, user});
    end
    @(negedge clk); rst_n = 1;
    step(0, 16'h0000, 8'h00, "R1 idle");
    // R2 canonical ports
    step(1, 16'h5000, 8'h3C, "R2 prg and");
    step(1, 16'h5001, 8'hA5, "R2 prg xor");
    step(1, 16'h5002, 8'h0F, "R2 chr and");
    step(1, 16'h5003, 8'hF0, "R2 chr xor");
    // R3 mirrors
    step(1, 16'h5FF8, 8'h11, "R3 mirror prg and");
    step(1, 16'h5A09, 8'h22, "R3 mirror prg xor");
    step(1, 16'h5332, 8'h33, "R3 mirror chr and");
    step(1, 16'h5C0B, 8'h44, "R3 mirror chr xor");
    // R4 control plus mask
    step(1, 16'h5004, 8'h81, "R4 ctrl+prg and");
    step(1, 16'h5F07, 8'h1D, "R4 ctrl+chr xor");
    // R5 no A2 keeps control
    step(1, 16'h5001, 8'hEE, "R5 ctrl held");
    step(1, 16'h5FFA, 8'h77, "R5 ctrl held mirror");
    // R6 bit5 clear
    step(1, 16'h6000, 8'h5A, "R6 low window ignored");
    step(1, 16'h7FFF, 8'h5B, "R6 low window ignored");
    step(1, 16'h8000, 8'h5C, "R6 user high");
    step(1, 16'hFFFF, 8'hC3, "R6 user top");
    // R11 window writes keep user
    step(1, 16'h5005, 8'h00, "R11 window keeps user");
    step(1, 16'h5006, 8'h20, "R7 set bit5");
    // R7 bit5 set
    step(1, 16'h6000, 8'h96, "R7 user at 6000");
    step(1, 16'h7ABC, 8'h69, "R7 user at 7ABC");
    // R8 exact data
    step(1, 16'hC000, 8'hFF, "R8 user FF");
    step(1, 16'hA123, 8'h00, "R8 user 00");
    step(1, 16'h9001, 8'h01, "R11 user write keeps masks");
    // R9 below window
    step(1, 16'h4FFF, 8'hAA, "R9 4FFF ignored");
    step(1, 16'h4020, 8'h55, "R9 4020 ignored");
    step(1, 16'h0004, 8'h99, "R9 0004 ignored");
    // R10 no strobe
    step(0, 16'h5004, 8'hBB, "R10 no strobe ctrl");
    step(0, 16'hE000, 8'hCC, "R10 no strobe user");
    step(1, 16'h5004, 8'h00, "R7 clear bit5");
    step(1, 16'h6FFF, 8'h42, "R6 ignored after clear");
    step(0, 16'h0000, 8'h00, "idle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule